// File: doc/BRIEF.md
# Interrupt-Triggered DMA Channel Dispatcher

The dispatcher sits between the interrupt sources and the CPU interrupt input. Each of its DMA channels holds a trigger vector and a transfer count, both loaded by software through a single write port. When an interrupt arrives whose vector code equals a channel's trigger vector, the event is taken by that channel: the channel asks the bus for one transfer step, and the CPU never sees the interrupt. An interrupt that no channel claims goes on to the CPU one cycle later, with its vector code unchanged.

Every completed step, marked by a one-cycle acknowledge from the bus side, lowers the channel's count by one. The step that brings the count to zero ends the run. The channel then pulses its end-of-transfer interrupt, clears its own trigger vector and stops claiming that source. When several channels hold the same vector, the lowest-numbered one claims the event. Once it has run out, the next one up takes over, so runs chain without software help. To continue DMA on an exhausted channel, software writes its vector again, usually from the end-of-transfer handler.

A channel that is already waiting for an acknowledge keeps one further trigger pending. Triggers beyond that one are dropped.

Top module: `irq_dma_dispatch`

## Requirements
- R1: After reset no transfer request, no end-of-transfer pulse and no CPU interrupt is active, and every channel's trigger vector is 0.
- R2: A trigger vector of 0 marks a channel as unassigned, and such a channel never claims an interrupt, including one with vector code 0.
- R3: An interrupt that no channel claims sets `cpu_irq_valid` for exactly one cycle, in the cycle after it arrives, with `cpu_irq_vec` equal to its vector code. A claimed interrupt is not forwarded.
- R4: A claimed interrupt raises the winning channel's bit of `xfer_req` in the next cycle. The bit stays high until that channel's `xfer_ack` bit is seen.
- R5: Each acknowledge lowers the channel's count by one. An acknowledge seen while the count is 1 ends the run: in the next cycle the channel's `end_irq` bit is high for exactly one cycle and its request is low. An acknowledge with a higher count ends nothing.
- R6: When a run ends, the channel's trigger vector is cleared, so later interrupts with that code are no longer claimed by it.
- R7: When several channels hold the matching vector, only the lowest-numbered one is triggered.
- R8: Once the lower channel has ended, the next matching interrupt triggers the next higher channel holding that vector. This includes an interrupt that arrives in the same cycle as the acknowledge that ends the lower channel.
- R9: A trigger that arrives while the channel waits for an acknowledge is held, one deep. After a non-final acknowledge with a trigger held, the request stays high without a gap. Further triggers that arrive while one is already held are dropped.
- R10: A vector write to a channel re-arms it. A vector write in the same cycle as that channel's ending acknowledge wins over the automatic clear.
- R11: A configuration write with `cfg_we`=1 targets the channel `cfg_sel`. With `cfg_kind`=0 it loads the trigger vector from `cfg_data[5:0]`. With `cfg_kind`=1 it loads the count from `cfg_data[15:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| irq_valid | input | 1 | Incoming interrupt event, one cycle per event |
| irq_vec | input | 6 | Vector code of the incoming interrupt |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Channel index for the write |
| cfg_kind | input | 1 | 0: trigger vector, 1: transfer count |
| cfg_data | input | 16 | Write data |
| xfer_ack | input | 4 | Per-channel one-cycle step acknowledge |
| xfer_req | output | 4 | Per-channel transfer request |
| end_irq | output | 4 | Per-channel end-of-transfer pulse |
| cpu_irq_valid | output | 1 | Forwarded interrupt to the CPU |
| cpu_irq_vec | output | 6 | Vector code of the forwarded interrupt |

## Verification
The assertions take for granted that the bus side pulses a channel's `xfer_ack` bit only while that channel's `xfer_req` bit is high. They also take for granted that a count load does not coincide with an acknowledge on the same channel, because the step check compares the new count with the old one. The stimulus acknowledges only channels whose request it has just seen high, and it makes every count write in a cycle with no acknowledge pending. Interrupts are single-cycle pulses driven between clock edges.

// File: rtl/irq_dma_pkg.sv
package irq_dma_pkg;
  typedef enum logic {
    CH_IDLE = 1'b0,
    CH_BUSY = 1'b1
  } ch_state_e;

  localparam logic CFG_KIND_VEC = 1'b0;
  localparam logic CFG_KIND_CNT = 1'b1;
endpackage

// File: rtl/irq_dma_match.sv
module irq_dma_match #(
  parameter int NCH = 4,
  parameter int VW  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCH-1:0][VW-1:0]  chan_vec,
  input  logic [NCH-1:0]          chan_excl,
  input  logic                    irq_valid,
  input  logic [VW-1:0]           irq_vec,
  output logic [NCH-1:0]          grant,
  output logic                    hit
);
  logic [NCH-1:0] cand;
  logic           taken;

  for (genvar gi = 0; gi < NCH; gi++) begin : g_cmp
    assign cand[gi] = irq_valid && (chan_vec[gi] != '0) &&
                      (chan_vec[gi] == irq_vec) && !chan_excl[gi];
  end

  // lowest index claims the event
  always_comb begin
    grant = '0;
    taken = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (cand[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  assign hit = |cand;

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R7
  AST_HIT_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (grant != '0)); // R7
endmodule

// File: rtl/irq_dma_chan.sv
module irq_dma_chan
  import irq_dma_pkg::*;
#(
  parameter int VW = 6,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_vec,
  input  logic          wr_cnt,
  input  logic [CW-1:0] wr_data,
  input  logic          trig,
  input  logic          ack,
  output logic [VW-1:0] vec_o,
  output logic          expiring_o,
  output logic          req_o,
  output logic          end_o
);
  ch_state_e     state_q, state_d;
  logic          pend_q, pend_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [VW-1:0] vec_q, vec_d;
  logic          end_q, end_d;
  logic          step, expire;
  logic          cnt_en, vec_en;

  assign step   = (state_q == CH_BUSY) && ack;
  assign expire = step && (cnt_q == CW'(1));
  assign cnt_en = step || wr_cnt;
  assign vec_en = expire || wr_vec;

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    cnt_d   = cnt_q;
    vec_d   = vec_q;
    end_d   = expire;
    if (step) cnt_d = cnt_q - CW'(1);
    if (wr_cnt) cnt_d = wr_data;
    if (expire) begin
      vec_d   = '0;
      state_d = CH_IDLE;
      pend_d  = 1'b0;
    end else if (step) begin
      if (pend_q) pend_d = 1'b0;
      else        state_d = CH_IDLE;
    end
    if (trig) begin
      if (state_d == CH_IDLE) state_d = CH_BUSY;
      else                    pend_d  = 1'b1;
    end
    if (wr_vec) vec_d = wr_data[VW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_IDLE;
      pend_q  <= 1'b0;
      cnt_q   <= '0;
      vec_q   <= '0;
      end_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      end_q   <= end_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (vec_en) vec_q <= vec_d;
    end
  end

  assign vec_o      = vec_q;
  assign expiring_o = expire;
  assign req_o      = (state_q == CH_BUSY);
  assign end_o      = end_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack) |=> req_o); // R4
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && ack && !wr_cnt) |=> (cnt_q == $past(cnt_q) - CW'(1))); // R5
  AST_END_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |=> !end_o); // R5
  AST_END_CLEARS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |-> ((vec_q == '0) || $past(wr_vec))); // R6
endmodule

// File: rtl/irq_dma_dispatch.sv
module irq_dma_dispatch
  import irq_dma_pkg::*;
#(
  parameter int NCH = 4,
  parameter int VW  = 6,
  parameter int CW  = 16,
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           irq_valid,
  input  logic [VW-1:0]  irq_vec,
  input  logic           cfg_we,
  input  logic [SW-1:0]  cfg_sel,
  input  logic           cfg_kind,
  input  logic [CW-1:0]  cfg_data,
  input  logic [NCH-1:0] xfer_ack,
  output logic [NCH-1:0] xfer_req,
  output logic [NCH-1:0] end_irq,
  output logic           cpu_irq_valid,
  output logic [VW-1:0]  cpu_irq_vec
);
  logic [NCH-1:0][VW-1:0] chan_vec;
  logic [NCH-1:0]         chan_expiring;
  logic [NCH-1:0]         grant;
  logic                   hit;
  logic                   fwd_v_q, fwd_v_d;
  logic [VW-1:0]          fwd_vec_q, fwd_vec_d;
  logic                   fwd_vec_en;

  irq_dma_match #(.NCH(NCH), .VW(VW)) i_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_vec  (chan_vec),
    .chan_excl (chan_expiring),
    .irq_valid (irq_valid),
    .irq_vec   (irq_vec),
    .grant     (grant),
    .hit       (hit)
  );

  for (genvar gc = 0; gc < NCH; gc++) begin : g_chan
    logic sel_me;
    assign sel_me = cfg_we && (cfg_sel == SW'(gc));
    irq_dma_chan #(.VW(VW), .CW(CW)) i_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_vec     (sel_me && (cfg_kind == CFG_KIND_VEC)),
      .wr_cnt     (sel_me && (cfg_kind == CFG_KIND_CNT)),
      .wr_data    (cfg_data),
      .trig       (grant[gc]),
      .ack        (xfer_ack[gc]),
      .vec_o      (chan_vec[gc]),
      .expiring_o (chan_expiring[gc]),
      .req_o      (xfer_req[gc]),
      .end_o      (end_irq[gc])
    );
  end

  always_comb begin
    fwd_v_d    = irq_valid && !hit;
    fwd_vec_en = fwd_v_d;
    fwd_vec_d  = irq_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_v_q   <= 1'b0;
      fwd_vec_q <= '0;
    end else begin
      fwd_v_q <= fwd_v_d;
      if (fwd_vec_en) fwd_vec_q <= fwd_vec_d;
    end
  end

  assign cpu_irq_valid = fwd_v_q;
  assign cpu_irq_vec   = fwd_vec_q;

  AST_CLAIMED_NOT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && hit) |=> !cpu_irq_valid); // R3
  AST_FWD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !hit) |=> (cpu_irq_valid && cpu_irq_vec == $past(irq_vec))); // R3
  AST_CLAIM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |=> ((xfer_req & $past(grant)) == $past(grant))); // R4
endmodule

// File: tb/test_irq_dma_dispatch.sv
module test_irq_dma_dispatch;
  localparam int CLK_P = 10;

  logic        clk, rst_n;
  logic        irq_valid;
  logic [5:0]  irq_vec;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic        cfg_kind;
  logic [15:0] cfg_data;
  logic [3:0]  xfer_ack;
  logic [3:0]  xfer_req;
  logic [3:0]  end_irq;
  logic        cpu_irq_valid;
  logic [5:0]  cpu_irq_vec;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  irq_dma_dispatch i_irq_dma_dispatch (
    .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_vec(irq_vec),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_kind(cfg_kind), .cfg_data(cfg_data),
    .xfer_ack(xfer_ack), .xfer_req(xfer_req), .end_irq(end_irq),
    .cpu_irq_valid(cpu_irq_valid), .cpu_irq_vec(cpu_irq_vec)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_P / 2) clk = ~clk;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(int sel, bit kind, int data);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_kind = kind; cfg_data = 16'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic fire(int v);
    irq_valid = 1'b1; irq_vec = 6'(v);
    @(negedge clk);
    irq_valid = 1'b0;
  endtask

  task automatic ackc(int ch);
    xfer_ack = 4'b0001 << ch;
    @(negedge clk);
    xfer_ack = '0;
  endtask

  task automatic t_reset;
    check("R1 req", 32'(xfer_req), 0);
    check("R1 end", 32'(end_irq), 0);
    check("R1 cpu", 32'(cpu_irq_valid), 0);
  endtask

  task automatic t_forward;
    fire(5);
    check("R3 fwd valid", 32'(cpu_irq_valid), 1);
    check("R3 fwd vec", 32'(cpu_irq_vec), 5);
    check("R1 unassigned no req", 32'(xfer_req), 0);
    @(negedge clk);
    check("R3 one cycle", 32'(cpu_irq_valid), 0);
    cfg(1, 1'b1, 5);
    fire(0);
    check("R2 vec0 fwd", 32'(cpu_irq_valid), 1);
    check("R2 vec0 no req", 32'(xfer_req), 0);
  endtask

  task automatic t_basic;
    cfg(0, 1'b0, 10);
    cfg(0, 1'b1, 2);
    fire(10);
    check("R4 req", 32'(xfer_req), 4'b0001);
    check("R3 claimed not fwd", 32'(cpu_irq_valid), 0);
    @(negedge clk);
    check("R4 hold", 32'(xfer_req), 4'b0001);
    ackc(0);
    check("R5 step req drop", 32'(xfer_req), 0);
    check("R11 count 2 no end", 32'(end_irq), 0);
    fire(10);
    check("R4 req again", 32'(xfer_req), 4'b0001);
    ackc(0);
    check("R5 end pulse", 32'(end_irq), 4'b0001);
    check("R5 req low", 32'(xfer_req), 0);
    @(negedge clk);
    check("R5 end one cycle", 32'(end_irq), 0);
    fire(10);
    check("R6 fwd after clear", 32'(cpu_irq_valid), 1);
    check("R6 no req", 32'(xfer_req), 0);
  endtask

  task automatic t_priority;
    cfg(1, 1'b0, 20); cfg(1, 1'b1, 1);
    cfg(2, 1'b0, 20); cfg(2, 1'b1, 1);
    fire(20);
    check("R7 lowest wins", 32'(xfer_req), 4'b0010);
    ackc(1);
    check("R7 end ch1", 32'(end_irq), 4'b0010);
    fire(20);
    check("R8 chain ch2", 32'(xfer_req), 4'b0100);
    ackc(2);
    check("R8 end ch2", 32'(end_irq), 4'b0100);
    fire(20);
    check("R6 both cleared fwd", 32'(cpu_irq_valid), 1);
  endtask

  task automatic t_same_cycle;
    cfg(0, 1'b0, 30); cfg(0, 1'b1, 1);
    cfg(3, 1'b0, 30); cfg(3, 1'b1, 1);
    fire(30);
    check("R7 ch0 first", 32'(xfer_req), 4'b0001);
    xfer_ack = 4'b0001; irq_valid = 1'b1; irq_vec = 6'd30;
    @(negedge clk);
    xfer_ack = '0; irq_valid = 1'b0;
    check("R8 same-cycle end", 32'(end_irq), 4'b0001);
    check("R8 same-cycle chain", 32'(xfer_req), 4'b1000);
    check("R8 not fwd", 32'(cpu_irq_valid), 0);
    ackc(3);
    check("R8 end ch3", 32'(end_irq), 4'b1000);
  endtask

  task automatic t_pending;
    cfg(2, 1'b0, 40); cfg(2, 1'b1, 10);
    fire(40);
    check("R9 req", 32'(xfer_req), 4'b0100);
    fire(40);
    fire(40);
    check("R9 pending not fwd", 32'(cpu_irq_valid), 0);
    ackc(2);
    check("R9 held trigger keeps req", 32'(xfer_req), 4'b0100);
    ackc(2);
    check("R9 extra trigger dropped", 32'(xfer_req), 0);
  endtask

  task automatic t_reload;
    cfg(0, 1'b0, 50); cfg(0, 1'b1, 1);
    fire(50);
    check("R10 req", 32'(xfer_req), 4'b0001);
    xfer_ack = 4'b0001;
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_kind = 1'b0; cfg_data = 16'd50;
    @(negedge clk);
    xfer_ack = '0; cfg_we = 1'b0;
    check("R10 end", 32'(end_irq), 4'b0001);
    cfg(0, 1'b1, 1);
    fire(50);
    check("R10 write wins rearm", 32'(xfer_req), 4'b0001);
    check("R10 not fwd", 32'(cpu_irq_valid), 0);
    ackc(0);
    check("R10 end again", 32'(end_irq), 4'b0001);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; irq_valid = 1'b0; irq_vec = '0; cfg_we = 1'b0;
    cfg_sel = '0; cfg_kind = 1'b0; cfg_data = '0; xfer_ack = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_forward();
    t_basic();
    t_priority();
    t_same_cycle();
    t_pending();
    t_reload();
    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule